// File: doc/BRIEF.md
# Programmable Parallel Port Register Interface

This block is the processor-facing register front end of a parallel I/O controller with three 8-bit ports, named A, B and C. A host reaches it through an 8-bit data bus, an active-low select, active-low read and write strobes and a two-bit register address. Three addresses reach the ports. The fourth address is a control register that can be written but not read.

A control write takes one of two forms, chosen by its top bit. The mode-set form fixes the direction of port A, port B and each half of port C. It also sets the mode numbers of the two port groups and clears every output latch. The single-bit form sets or clears one chosen bit of port C and leaves every other bit and the configuration as they were, so no read-modify-write is needed.

In the basic mode handled here, each port or half-port is either a latched output with its tri-state enable asserted, or an input whose pins pass through a synchronizer before they can be read. The group mode fields go out on ports so that separate handshake logic can use them.

Top module: `ppio_regif`

## Requirements
- R1: After reset the stored configuration equals the `RESET_CW` parameter (default 8'h9B). All pin enables are low, `grpa_mode` is 0, `grpb_mode` is 0, and every output latch is 8'h00.
- R2: A write with `cs_n` low and `wr_n` low at a rising clock edge loads `dat_i` into a latch after that edge. Address 2'b00 selects port A, 2'b01 port B and 2'b10 port C.
- R3: While `cs_n` is high, writes change no latch and no configuration, and `dat_oe` stays low.
- R4: A control write (address 2'b11) with bit 7 = 1 is a mode-set word. Bit 4 sets the port A direction, bit 3 the port C upper direction, bit 1 the port B direction and bit 0 the port C lower direction, where 1 = input and 0 = output, and each pin enable is the inverse of its bit. `grpa_mode` takes bits 6:5 and `grpb_mode` takes bit 2.
- R5: A mode-set word clears the port A, B and C output latches to 8'h00.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C bit chosen by bits 3:1. Bits 6:4 are ignored, and the other port C bits, the directions and the modes stay unchanged.
- R7: A read (`cs_n` and `rd_n` low) of a port or half-port set as output returns its latch value on `dat_o`.
- R8: A read of a port or half-port set as input returns its pins, delayed by `SYNC_STAGES` (default 2) rising edges. Each half of port C follows its own direction.
- R9: A read of the control address returns 8'h00.
- R10: `dat_oe` is high only while `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dat_i | input | 8 | Write data from host |
| dat_o | output | 8 | Read data to host |
| dat_oe | output | 1 | Host data bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe | output | 1 | Port A pin drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe | output | 1 | Port B pin drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_hi | output | 1 | Port C bits 7:4 drive enable |
| pc_oe_lo | output | 1 | Port C bits 3:0 drive enable |
| grpa_mode | output | 2 | Group A mode field |
| grpb_mode | output | 1 | Group B mode field |

## Verification
Each port gets a distinct data pattern so that a wrong address decode shows up as a wrong value. Several mode-set words are used, each with a different mix of direction and mode bits, which exposes swapped or inverted fields. Port C is read with one half as input and the other as output, which shows whether the split into halves is right. Single-bit words are sent with bits 6:4 set and with both set and clear values, so a field taken from the wrong bits or a change to a neighbouring bit is caught. The synchronizer delay is checked one edge early and again on the exact edge.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

   localparam int PPIO_W = 8;
   localparam int PPIO_SELW = $clog2(PPIO_W);

   typedef enum logic [1:0] {
      SEL_A   = 2'b00,
      SEL_B   = 2'b01,
      SEL_C   = 2'b10,
      SEL_CTL = 2'b11
   } ppio_sel_e;

   typedef struct packed {
      logic [1:0] a_mode;
      logic       a_in;
      logic       c_hi_in;
      logic       b_mode;
      logic       b_in;
      logic       c_lo_in;
   } ppio_cfg_t;

   function automatic ppio_cfg_t ppio_decode(input logic [6:0] w);
      ppio_cfg_t c;
      c.a_mode  = w[6:5];
      c.a_in    = w[4];
      c.c_hi_in = w[3];
      c.b_mode  = w[2];
      c.b_in    = w[1];
      c.c_lo_in = w[0];
      return c;
   endfunction

endpackage

// File: rtl/ppio_sync.sv
module ppio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         always_ff @(posedge clk or posedge rst) begin
            if (rst) st[s] <= '0;
            else if (s == 0) st[s] <= d;
            else st[s] <= st[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter logic [7:0] RESET_CW = 8'h9B
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_ctl,
   input  logic [PPIO_W-1:0]    wdata,
   output ppio_cfg_t            cfg,
   output logic                 mode_wr,
   output logic                 bit_wr,
   output logic [PPIO_SELW-1:0] bit_sel,
   output logic                 bit_val
);
   logic [6:0] cw_q;

   // top bit tells the two command formats apart
   assign mode_wr = wr_ctl &  wdata[7];
   assign bit_wr  = wr_ctl & ~wdata[7];
   assign bit_sel = wdata[3:1];
   assign bit_val = wdata[0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) cw_q <= RESET_CW[6:0];
      else if (mode_wr) cw_q <= wdata[6:0];
   end

   assign cfg = ppio_decode(cw_q);
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BITOP   = 1'b0,
   localparam int SW         = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          bit_en,
   input  logic [SW-1:0] bit_sel,
   input  logic          bit_val,
   input  logic [W-1:0]  in_mask,
   input  logic [W-1:0]  pin_i,
   output logic [W-1:0]  lat_o,
   output logic [W-1:0]  rd_o
);
   logic [W-1:0] lat_q;
   logic [W-1:0] lat_d;
   logic [W-1:0] pin_s;

   generate
      if (HAS_BITOP) begin : g_bitop
         always_comb begin
            lat_d = lat_q;
            if (clr) lat_d = '0;
            else if (wr_en) lat_d = wr_data;
            else if (bit_en) lat_d[bit_sel] = bit_val;
         end
      end else begin : g_plain
         logic unused_bit;
         assign unused_bit = bit_en ^ bit_val ^ (^bit_sel);
         always_comb begin
            lat_d = lat_q;
            if (clr) lat_d = '0;
            else if (wr_en) lat_d = wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) lat_q <= '0;
      else lat_q <= lat_d;
   end

   ppio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
   );

   assign lat_o = lat_q;
   assign rd_o  = (pin_s & in_mask) | (lat_q & ~in_mask);
endmodule

// File: rtl/ppio_regif.sv
module ppio_regif
   import ppio_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RESET_CW    = 8'h9B
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cs_n,
   input  logic        rd_n,
   input  logic        wr_n,
   input  logic [1:0]  addr,
   input  logic [7:0]  dat_i,
   output logic [7:0]  dat_o,
   output logic        dat_oe,
   input  logic [7:0]  pa_i,
   output logic [7:0]  pa_o,
   output logic        pa_oe,
   input  logic [7:0]  pb_i,
   output logic [7:0]  pb_o,
   output logic        pb_oe,
   input  logic [7:0]  pc_i,
   output logic [7:0]  pc_o,
   output logic        pc_oe_hi,
   output logic        pc_oe_lo,
   output logic [1:0]  grpa_mode,
   output logic        grpb_mode
);
   localparam int HALF = PPIO_W / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ppio_regif: SYNC_STAGES must be at least 2");
      end
      if (RESET_CW[7] != 1'b1) begin : g_bad_rst
         $error("ppio_regif: RESET_CW must be a mode-set word");
      end
   endgenerate

   ppio_sel_e            sel;
   logic                 wr_act;
   logic                 mode_wr, bit_wr, bit_val;
   logic [PPIO_SELW-1:0] bit_sel;
   ppio_cfg_t            cfg;
   logic [PPIO_W-1:0]    rd_a, rd_b, rd_c;
   logic [PPIO_W-1:0]    mask_a, mask_b, mask_c;

   assign sel    = ppio_sel_e'(addr);
   assign wr_act = ~cs_n & ~wr_n;

   ppio_ctrl #(.RESET_CW(RESET_CW)) u_ctrl (
      .clk(clk), .rst(rst),
      .wr_ctl(wr_act && sel == SEL_CTL), .wdata(dat_i),
      .cfg(cfg), .mode_wr(mode_wr), .bit_wr(bit_wr),
      .bit_sel(bit_sel), .bit_val(bit_val)
   );

   assign mask_a = {PPIO_W{cfg.a_in}};
   assign mask_b = {PPIO_W{cfg.b_in}};
   assign mask_c = {{HALF{cfg.c_hi_in}}, {HALF{cfg.c_lo_in}}};

   ppio_port #(.W(PPIO_W), .SYNC_STAGES(SYNC_STAGES), .HAS_BITOP(1'b0)) u_pa (
      .clk(clk), .rst(rst), .clr(mode_wr),
      .wr_en(wr_act && sel == SEL_A), .wr_data(dat_i),
      .bit_en(1'b0), .bit_sel('0), .bit_val(1'b0),
      .in_mask(mask_a), .pin_i(pa_i), .lat_o(pa_o), .rd_o(rd_a)
   );

   ppio_port #(.W(PPIO_W), .SYNC_STAGES(SYNC_STAGES), .HAS_BITOP(1'b0)) u_pb (
      .clk(clk), .rst(rst), .clr(mode_wr),
      .wr_en(wr_act && sel == SEL_B), .wr_data(dat_i),
      .bit_en(1'b0), .bit_sel('0), .bit_val(1'b0),
      .in_mask(mask_b), .pin_i(pb_i), .lat_o(pb_o), .rd_o(rd_b)
   );

   ppio_port #(.W(PPIO_W), .SYNC_STAGES(SYNC_STAGES), .HAS_BITOP(1'b1)) u_pc (
      .clk(clk), .rst(rst), .clr(mode_wr),
      .wr_en(wr_act && sel == SEL_C), .wr_data(dat_i),
      .bit_en(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val),
      .in_mask(mask_c), .pin_i(pc_i), .lat_o(pc_o), .rd_o(rd_c)
   );

   always_comb begin
      unique case (sel)
         SEL_A:   dat_o = rd_a;
         SEL_B:   dat_o = rd_b;
         SEL_C:   dat_o = rd_c;
         default: dat_o = '0;
      endcase
   end

   assign dat_oe    = ~cs_n & ~rd_n;
   assign pa_oe     = ~cfg.a_in;
   assign pb_oe     = ~cfg.b_in;
   assign pc_oe_hi  = ~cfg.c_hi_in;
   assign pc_oe_lo  = ~cfg.c_lo_in;
   assign grpa_mode = cfg.a_mode;
   assign grpb_mode = cfg.b_mode;
endmodule

// File: rtl/ppio_regif_chk.sv
module ppio_regif_chk (
   input logic       clk,
   input logic       rst,
   input logic       cs_n,
   input logic       rd_n,
   input logic       wr_n,
   input logic [1:0] addr,
   input logic [7:0] dat_i,
   input logic [7:0] dat_o,
   input logic       dat_oe,
   input logic [7:0] pa_o,
   input logic [7:0] pb_o,
   input logic [7:0] pc_o,
   input logic       pa_oe,
   input logic       pb_oe,
   input logic       pc_oe_hi,
   input logic       pc_oe_lo,
   input logic [1:0] grpa_mode,
   input logic       grpb_mode
);
   logic wr_go;
   assign wr_go = !cs_n && !wr_n;

   p_wr_a_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_go && addr == 2'b00) |=> pa_o == $past(dat_i));

   p_nocs_r3: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o)
                && $stable(pa_oe) && $stable(grpa_mode)));

   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_go && addr == 2'b11 && dat_i[7]) |=> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00));

   p_bit_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_go && addr == 2'b11 && !dat_i[7]) |=> pc_o[$past(dat_i[3:1])] == $past(dat_i[0]));

   p_bit_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_go && addr == 2'b11 && !dat_i[7]) |=> ($stable(grpa_mode) && $stable(grpb_mode)
         && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe_hi) && $stable(pc_oe_lo)));

   p_ctl_rd_r9: assert property (@(posedge clk) disable iff (rst)
      (dat_oe && addr == 2'b11) |-> dat_o == 8'h00);

   p_oe_r10: assert property (@(posedge clk) disable iff (rst)
      dat_oe |-> (!cs_n && !rd_n));
endmodule

bind ppio_regif ppio_regif_chk u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
   .addr(addr), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
   .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o),
   .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe_hi(pc_oe_hi), .pc_oe_lo(pc_oe_lo),
   .grpa_mode(grpa_mode), .grpb_mode(grpb_mode)
);

// File: tb/sim_ppio_regif.sv
`timescale 1ns/1ps
module sim_ppio_regif;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] dat_i = 8'h00;
   logic [7:0] dat_o;
   logic dat_oe;
   logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
   logic [7:0] pa_o, pb_o, pc_o;
   logic pa_oe, pb_oe, pc_oe_hi, pc_oe_lo;
   logic [1:0] grpa_mode;
   logic grpb_mode;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } sb_item_t;
   sb_item_t sbq[$];
   logic mon_rd = 1'b0;

   always #2 clk = ~clk;

   ppio_regif u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
      .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
      .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
      .pc_i(pc_i), .pc_o(pc_o), .pc_oe_hi(pc_oe_hi), .pc_oe_lo(pc_oe_lo),
      .grpa_mode(grpa_mode), .grpb_mode(grpb_mode)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items while a read is on the bus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_rd && sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            chk({it.tag, " read data"}, dat_o, it.exp);
            chk({it.tag, " R10 bus enable"}, {7'd0, dat_oe}, 8'h01);
         end
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
      @(negedge clk);
      cs_n = sel_n; wr_n = 1'b0; addr = a; dat_i = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      sb_item_t it;
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      mon_rd = 1'b1;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; mon_rd = 1'b0;
   endtask

   task automatic cfg_chk(input string tag, input logic [7:0] exp_oe, input logic [2:0] exp_md);
      chk({tag, " enables"}, {4'd0, pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, exp_oe);
      chk({tag, " modes"}, {5'd0, grpa_mode, grpb_mode}, {5'd0, exp_md});
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      pa_i = 8'h5A;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset configuration: all inputs, modes zero, latches clear
      cfg_chk("R1", 8'h00, 3'b000);
      chk("R1 latches", pa_o | pb_o | pc_o, 8'h00);
      // R8: port A is input after reset
      bus_rd(2'b00, 8'h5A, "R8 port A input");

      // R4: all output, mode 0
      bus_wr(2'b11, 8'h80, 1'b0);
      cfg_chk("R4 word 80", 8'h0F, 3'b000);
      // R2: address decode of the three latches
      bus_wr(2'b00, 8'h3C, 1'b0);
      bus_wr(2'b01, 8'hC3, 1'b0);
      bus_wr(2'b10, 8'h81, 1'b0);
      chk("R2 port A", pa_o, 8'h3C);
      chk("R2 port B", pb_o, 8'hC3);
      chk("R2 port C", pc_o, 8'h81);
      // R7: output ports read back their latches
      bus_rd(2'b00, 8'h3C, "R7 port A");
      bus_rd(2'b01, 8'hC3, "R7 port B");
      bus_rd(2'b10, 8'h81, "R7 port C");

      // R3: deselected write ignored, deselected read leaves bus off
      bus_wr(2'b00, 8'hFF, 1'b1);
      bus_wr(2'b11, 8'h9B, 1'b1);
      chk("R3 port A kept", pa_o, 8'h3C);
      cfg_chk("R3 config kept", 8'h0F, 3'b000);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b0; addr = 2'b00;
      @(posedge clk); #1;
      chk("R3 R10 bus enable off", {7'd0, dat_oe}, 8'h00);
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b0;
      @(posedge clk); #1;
      chk("R10 bus enable needs read", {7'd0, dat_oe}, 8'h00);
      @(negedge clk);
      cs_n = 1'b1;

      // R6: set bit 5 (bits 3:1 = 101, bit0 = 1)
      bus_wr(2'b11, 8'h0B, 1'b0);
      chk("R6 set bit5", pc_o, 8'hA1);
      // R6: clear bit 7 with bits 6:4 set (ignored)
      bus_wr(2'b11, 8'h7E, 1'b0);
      chk("R6 clear bit7", pc_o, 8'h21);
      cfg_chk("R6 config kept", 8'h0F, 3'b000);
      chk("R6 port A kept", pa_o, 8'h3C);

      // R5 and R4: word CD: A mode 2 out, C upper in, B mode 1 out, C lower in
      bus_wr(2'b11, 8'hCD, 1'b0);
      chk("R5 port A cleared", pa_o, 8'h00);
      chk("R5 port B cleared", pb_o, 8'h00);
      chk("R5 port C cleared", pc_o, 8'h00);
      cfg_chk("R4 word CD", 8'h0C, 3'b101);
      // R4: word B4: A mode 1 in, C upper out, B mode 1 out, C lower out
      bus_wr(2'b11, 8'hB4, 1'b0);
      cfg_chk("R4 word B4", 8'h07, 3'b011);

      // R8: port C split, upper input, lower output (word 88)
      bus_wr(2'b11, 8'h88, 1'b0);
      bus_wr(2'b10, 8'h5F, 1'b0);
      pc_i = 8'hA3;
      repeat (3) @(negedge clk);
      bus_rd(2'b10, 8'hAF, "R8 port C halves");

      // R9: control address not readable
      bus_rd(2'b11, 8'h00, "R9 control read");

      // R8: synchronizer latency on port A as input (word 90)
      bus_wr(2'b11, 8'h90, 1'b0);
      pa_i = 8'h11;
      repeat (3) @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = 2'b00;
      pa_i = 8'hE7;
      @(posedge clk); #1;
      chk("R8 one edge still old", dat_o, 8'h11);
      @(posedge clk); #1;
      chk("R8 two edges new", dat_o, 8'hE7);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;

      repeat (2) @(negedge clk);
      chk("scoreboard drained", 8'(sbq.size()), 8'h00);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule